// File: doc/BRIEF.md
# Mode-Switched SPI Control Register

This block is the slave-side front end between one SPI master and a shared SPI bus. A single access-mode input decides what the master's four SPI wires reach. With the mode input high, the serial stream shifts into a local 8-bit control byte that carries a bus-request flag and a 5-bit target device address. With the mode input low, the clock, data-out, select and data-in lines are routed straight through to the shared bus.

The request flag and the device address are offered to an external arbiter. The arbiter returns a grant flag, and the block reports it on the master's data-in line while the master talks to the control byte. A master asks for the bus by writing a byte with the request flag set. It then writes the same byte again and reads the reply of that second transfer: all zeros means the bus is its own, all ones means it is busy. It gives the bus up by writing a zero byte.

The master's SPI inputs are taken as asynchronous. They are brought into the system clock domain by a synchronizer, and SCLK edges are found by oversampling. The master runs SPI mode 0: SCLK idles low, the master samples on the rising edge, and the reply changes after the falling edge.

Top module: `spi_ctl_frontend`

## Requirements
- R1: After reset, the request output is 0 and the device address is 0. With the mode input high and select high, the master data-in line is 1 and the bus select is high.
- R2: In register mode, bits enter MSB first, one per rising SCLK edge. Only after the eighth bit does the byte commit: bit 7 goes to the request output and bits 4..0 go to the device address.
- R3: Bits 6 and 5 of a written byte have no effect. 0xE7 gives the same outputs as 0x87, and 0x60 gives the same outputs as 0x00.
- R4: A byte cut short by select going high changes nothing. The next byte is aligned from its own first bit.
- R5: In register mode, the reply byte is 0x00 when the grant flag is 1 at the start of the byte, and 0xFF when it is 0.
- R6: A change of the grant flag in the middle of a byte does not alter that byte's reply. The new value appears from the next byte on.
- R7: Writing 0x00 clears the request output and the device address.
- R8: With the mode input low, SCLK, data-out and select pass to the bus, and bus data-in passes back to the master. SCLK activity in this mode leaves the control byte unchanged.
- R9: With the mode input high, the bus sees select high, SCLK low and data-out low, whatever the master drives.
- R10: With the mode input high and select high, the master data-in line is 1 whatever the grant flag is.
- R11: Several bytes sent under one select each commit in turn, and the last one sets the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1: local control byte, 0: pass-through to the shared bus |
| m_sclk_i | input | 1 | Master SPI clock |
| m_mosi_i | input | 1 | Master data out |
| m_sel_n_i | input | 1 | Master select, active low |
| m_miso_o | output | 1 | Data to the master |
| bus_sclk_o | output | 1 | Shared bus SPI clock |
| bus_mosi_o | output | 1 | Shared bus data towards the slave |
| bus_sel_n_o | output | 1 | Shared bus select, active low |
| bus_miso_i | input | 1 | Shared bus data from the slave |
| grant_i | input | 1 | Ownership flag from the arbiter |
| req_o | output | 1 | Committed bus-request flag |
| dev_addr_o | output | 5 | Committed target device address |

## Verification
Two functions can meet at a byte boundary within one select: the commit of the byte just received and the sampling of the grant flag for the next reply. The bench sends two bytes back to back and flips the grant flag in the middle of the first one. The first reply must keep the old level, the second reply must take the new level, and the address must come from the second byte. The bench also cuts a byte short and then sends a full one, which confirms that the bit counter restarts from its first bit rather than carrying old bits over.

// File: rtl/spi_ctl_pkg.sv
// Package spi_ctl_pkg
// Shared types for the mode-switched SPI control front end.
// Assumes: one access-mode input whose high level selects the local register.
package spi_ctl_pkg;

    typedef enum logic {
        ACC_PASS = 1'b0,
        ACC_REG  = 1'b1
    } acc_mode_e;

    // Field order of the synchronizer bus inside the top module.
    typedef struct packed {
        logic mode;
        logic sel_n;
        logic mosi;
        logic sclk;
    } spi_pins_t;

endpackage

// File: rtl/spi_ctl_sync.sv
// Module spi_ctl_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent (no multi-bit coherency required);
// STAGES >= 1; reset loads RST_VAL into every stage.
module spi_ctl_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Purpose: move the input one stage closer to the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[gi] <= RST_VAL;
                end else begin
                    if (gi == 0) begin
                        stage_q[gi] <= d_i;
                    end else begin
                        stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi-1];
                    end
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_ctl_rxreg.sv
// Module spi_ctl_rxreg
// Receive shifter and committed control byte. Bits enter from the right on
// each rising SCLK strobe; the request flag and the device address update
// only when a full byte has arrived.
// Assumes: strobes are single-cycle pulses in the system clock domain;
// active_i low (deselected or pass-through) restarts byte alignment.
module spi_ctl_rxreg #(
    parameter int REG_W   = 8,
    parameter int ADDR_W  = 5,
    parameter int REQ_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              rise_i,
    input  logic              mosi_i,
    output logic              cnt_zero_o,
    output logic              wrap_o,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int              CNT_W    = (REG_W > 2) ? $clog2(REG_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REG_W - 1);

    logic [REG_W-1:0]  shift_q;
    logic [REG_W-1:0]  next_byte;
    logic [CNT_W-1:0]  cnt_q;
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done;

    assign next_byte  = {shift_q[REG_W-2:0], mosi_i};
    assign done       = active_i && rise_i && (cnt_q == LAST_CNT);
    assign wrap_o     = done;
    assign cnt_zero_o = (cnt_q == '0);
    assign req_o      = req_q;
    assign addr_o     = addr_q;

    // Purpose: shift in data bits and count the position within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (!active_i) begin
            cnt_q   <= '0;
        end else if (rise_i) begin
            shift_q <= next_byte;
            cnt_q   <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
        end
    end

    // Purpose: commit request flag and address on a complete byte only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else if (done) begin
            req_q  <= next_byte[REQ_BIT];
            addr_q <= next_byte[ADDR_W-1:0];
        end
    end

    // R2: committed state moves only after the last bit position was filled.
    p_commit_full_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != $past(req_q) || addr_q != $past(addr_q)) |-> ($past(cnt_q) == LAST_CNT))
        else $error("commit without a full byte");

    // R4: leaving the active state restarts alignment.
    p_align_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (cnt_q == '0))
        else $error("bit counter not cleared when inactive");

    // R8: no commit while inactive (pass-through or deselected).
    p_no_commit_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(req_q) && $stable(addr_q))
        else $error("control byte changed while inactive");

endmodule

// File: rtl/spi_ctl_reply.sv
// Module spi_ctl_reply
// Status reply shifter. The grant flag is sampled at the start of each
// byte and shifted out as all-zeros (granted) or all-ones (not granted),
// advancing on falling SCLK strobes.
// Assumes: SPI mode 0, so a byte boundary is the falling edge after the
// last rising edge; before the first rising edge the grant is tracked.
module spi_ctl_reply #(
    parameter int REG_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic fall_i,
    input  logic cnt_zero_i,
    input  logic wrap_i,
    input  logic grant_i,
    output logic bit_o
);

    logic [REG_W-1:0] reply_q;
    logic [REG_W-1:0] fill;
    logic             wrapped_q;

    assign fill  = grant_i ? '0 : '1;
    assign bit_o = reply_q[REG_W-1];

    // Purpose: load the reply at byte start, then shift it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_q   <= '1;
            wrapped_q <= 1'b0;
        end else if (!active_i) begin
            reply_q   <= fill;
            wrapped_q <= 1'b0;
        end else begin
            if (wrap_i) begin
                wrapped_q <= 1'b1;
            end
            if (fall_i) begin
                wrapped_q <= 1'b0;
                if (wrapped_q || cnt_zero_i) begin
                    reply_q <= fill;
                end else begin
                    reply_q <= {reply_q[REG_W-2:0], reply_q[0]};
                end
            end else if (cnt_zero_i && !wrapped_q && !wrap_i) begin
                reply_q <= fill;
            end
        end
    end

    // R5: a reply byte is always uniform, all zeros or all ones.
    p_reply_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(reply_q) == 0) || ($countones(reply_q) == REG_W))
        else $error("reply byte not uniform");

    // R6: inside a byte the reply level holds regardless of the grant flag.
    p_reply_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !cnt_zero_i && !wrapped_q) |=> (!active_i || $stable(bit_o)))
        else $error("reply level moved inside a byte");

endmodule

// File: rtl/spi_ctl_route.sv
// Module spi_ctl_route
// Wire routing between the master, the shared bus and the local reply.
// Pass-through forwards all four lines; register mode parks the bus idle
// and answers the master from the local reply or with a high level.
// Assumes: bus idle is select high, SCLK low, data low.
module spi_ctl_route
    import spi_ctl_pkg::*;
(
    input  logic mode_i,
    input  logic m_sclk_i,
    input  logic m_mosi_i,
    input  logic m_sel_n_i,
    input  logic reply_bit_i,
    input  logic bus_miso_i,
    output logic m_miso_o,
    output logic bus_sclk_o,
    output logic bus_mosi_o,
    output logic bus_sel_n_o
);

    acc_mode_e acc;

    assign acc = acc_mode_e'(mode_i);

    // Purpose: select the path of each SPI line from the access mode.
    always_comb begin
        if (acc == ACC_PASS) begin
            bus_sclk_o  = m_sclk_i;
            bus_mosi_o  = m_mosi_i;
            bus_sel_n_o = m_sel_n_i;
            m_miso_o    = bus_miso_i;
        end else begin
            bus_sclk_o  = 1'b0;
            bus_mosi_o  = 1'b0;
            bus_sel_n_o = 1'b1;
            m_miso_o    = m_sel_n_i ? 1'b1 : reply_bit_i;
        end
    end

endmodule

// File: rtl/spi_ctl_frontend.sv
// Module spi_ctl_frontend (top)
// Mode-switched SPI front end: a local request/address byte in register
// mode, a routed pass-through to a shared bus otherwise, with the
// arbiter's grant reported on the master's data-in line.
// Assumes: master SPI inputs are asynchronous and several times slower
// than clk; grant_i is synchronous to clk.
module spi_ctl_frontend
    import spi_ctl_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int ADDR_W      = 5,
    parameter int REQ_BIT     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              m_sclk_i,
    input  logic              m_mosi_i,
    input  logic              m_sel_n_i,
    output logic              m_miso_o,
    output logic              bus_sclk_o,
    output logic              bus_mosi_o,
    output logic              bus_sel_n_o,
    input  logic              bus_miso_i,
    input  logic              grant_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] dev_addr_o
);

    localparam int PIN_W = $bits(spi_pins_t);
    localparam spi_pins_t PIN_RST = '{mode: 1'b1, sel_n: 1'b1, mosi: 1'b0, sclk: 1'b0};

    spi_pins_t raw_pins;
    spi_pins_t syn_pins;
    logic      sclk_prev_q;
    logic      rise;
    logic      fall;
    logic      active;
    logic      cnt_zero;
    logic      wrap;
    logic      reply_bit;

    assign raw_pins = '{mode: mode_i, sel_n: m_sel_n_i, mosi: m_mosi_i, sclk: m_sclk_i};

    spi_ctl_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pins),
        .q_o   (syn_pins)
    );

    // Purpose: remember the last synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= syn_pins.sclk;
        end
    end

    assign rise   = syn_pins.sclk && !sclk_prev_q;
    assign fall   = !syn_pins.sclk && sclk_prev_q;
    assign active = (acc_mode_e'(syn_pins.mode) == ACC_REG) && !syn_pins.sel_n;

    spi_ctl_rxreg #(
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W),
        .REQ_BIT (REQ_BIT)
    ) rxreg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .rise_i     (rise),
        .mosi_i     (syn_pins.mosi),
        .cnt_zero_o (cnt_zero),
        .wrap_o     (wrap),
        .req_o      (req_o),
        .addr_o     (dev_addr_o)
    );

    spi_ctl_reply #(
        .REG_W (REG_W)
    ) reply_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .fall_i     (fall),
        .cnt_zero_i (cnt_zero),
        .wrap_i     (wrap),
        .grant_i    (grant_i),
        .bit_o      (reply_bit)
    );

    spi_ctl_route route_i (
        .mode_i      (mode_i),
        .m_sclk_i    (m_sclk_i),
        .m_mosi_i    (m_mosi_i),
        .m_sel_n_i   (m_sel_n_i),
        .reply_bit_i (reply_bit),
        .bus_miso_i  (bus_miso_i),
        .m_miso_o    (m_miso_o),
        .bus_sclk_o  (bus_sclk_o),
        .bus_mosi_o  (bus_mosi_o),
        .bus_sel_n_o (bus_sel_n_o)
    );

    // R9: register mode keeps the shared bus idle.
    p_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> (bus_sel_n_o && !bus_sclk_o && !bus_mosi_o))
        else $error("bus not idle in register mode");

    // R10: deselected in register mode, the master sees a high level.
    p_miso_high_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && m_sel_n_i) |-> m_miso_o)
        else $error("data-in low while deselected");

    // R8: pass-through returns the bus data to the master.
    p_pass_miso_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> (m_miso_o == bus_miso_i))
        else $error("pass-through data-in mismatch");

endmodule

// File: tb/spi_ctl_frontend_tb.sv
// Directed bench for spi_ctl_frontend: one task per scenario.
module spi_ctl_frontend_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b1;
    logic       m_sclk = 1'b0;
    logic       m_mosi = 1'b0;
    logic       m_sel_n = 1'b1;
    logic       m_miso;
    logic       bus_sclk;
    logic       bus_mosi;
    logic       bus_sel_n;
    logic       bus_miso = 1'b0;
    logic       grant = 1'b0;
    logic       req;
    logic [4:0] dev_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ctl_frontend dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .m_sclk_i    (m_sclk),
        .m_mosi_i    (m_mosi),
        .m_sel_n_i   (m_sel_n),
        .m_miso_o    (m_miso),
        .bus_sclk_o  (bus_sclk),
        .bus_mosi_o  (bus_mosi),
        .bus_sel_n_o (bus_sel_n),
        .bus_miso_i  (bus_miso),
        .grant_i     (grant),
        .req_o       (req),
        .dev_addr_o  (dev_addr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Send nbits of tx MSB first; flip grant after flip_at rising edges (-1: never).
    task automatic shift_bits(input logic [7:0] tx, input int nbits, input int flip_at,
                              output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            m_mosi = tx[7-i];
            tick(HALF_CLKS);
            rx = {rx[6:0], m_miso};
            m_sclk = 1'b1;
            if (i == flip_at) grant = ~grant;
            tick(HALF_CLKS);
            m_sclk = 1'b0;
        end
        tick(HALF_CLKS);
    endtask

    task automatic write_byte(input logic [7:0] tx, output logic [7:0] rx);
        m_sel_n = 1'b0;
        shift_bits(tx, 8, -1, rx);
        m_sel_n = 1'b1;
        tick(HALF_CLKS);
    endtask

    task automatic t_reset;
        check("R1 req", req, 0);
        check("R1 addr", dev_addr, 0);
        check("R1 miso", m_miso, 1);
        check("R1 bus_sel_n", bus_sel_n, 1);
    endtask

    task automatic t_write;
        logic [7:0] rx;
        grant = 1'b0;
        write_byte(8'h85, rx);
        check("R2 req", req, 1);
        check("R2 addr", dev_addr, 5'h05);
        check("R5 reply busy", rx, 8'hFF);
    endtask

    task automatic t_dont_care;
        logic [7:0] rx;
        write_byte(8'hE7, rx);
        check("R3 req 0xE7", req, 1);
        check("R3 addr 0xE7", dev_addr, 5'h07);
        write_byte(8'h60, rx);
        check("R3 req 0x60", req, 0);
        check("R3 addr 0x60", dev_addr, 0);
    endtask

    task automatic t_partial;
        logic [7:0] rx;
        write_byte(8'h85, rx);
        m_sel_n = 1'b0;
        shift_bits(8'h00, 5, -1, rx);
        m_sel_n = 1'b1;
        tick(HALF_CLKS);
        check("R4 req kept", req, 1);
        check("R4 addr kept", dev_addr, 5'h05);
        write_byte(8'h8A, rx);
        check("R4 realigned addr", dev_addr, 5'h0A);
    endtask

    task automatic t_handshake;
        logic [7:0] rx;
        grant = 1'b0;
        write_byte(8'h86, rx);
        check("R5 first reply", rx, 8'hFF);
        grant = req;
        write_byte(8'h86, rx);
        check("R5 second reply granted", rx, 8'h00);
    endtask

    task automatic t_boundary;
        logic [7:0] rx0;
        logic [7:0] rx1;
        grant = 1'b1;
        m_sel_n = 1'b0;
        shift_bits(8'h81, 8, 2, rx0);
        shift_bits(8'h8C, 8, -1, rx1);
        m_sel_n = 1'b1;
        tick(HALF_CLKS);
        check("R6 held reply", rx0, 8'h00);
        check("R6 next reply", rx1, 8'hFF);
        check("R11 last addr", dev_addr, 5'h0C);
        check("R11 last req", req, 1);
    endtask

    task automatic t_release;
        logic [7:0] rx;
        write_byte(8'h00, rx);
        check("R7 req", req, 0);
        check("R7 addr", dev_addr, 0);
        write_byte(8'h89, rx);
    endtask

    task automatic t_pass;
        logic [7:0] rx;
        mode = 1'b0;
        tick(HALF_CLKS);
        m_sel_n = 1'b0; m_sclk = 1'b1; m_mosi = 1'b1; bus_miso = 1'b1;
        #1;
        check("R8 bus_sel_n", bus_sel_n, 0);
        check("R8 bus_sclk", bus_sclk, 1);
        check("R8 bus_mosi", bus_mosi, 1);
        check("R8 miso high", m_miso, 1);
        bus_miso = 1'b0; m_sclk = 1'b0;
        #1;
        check("R8 miso low", m_miso, 0);
        check("R8 bus_sclk low", bus_sclk, 0);
        shift_bits(8'h00, 8, -1, rx);
        m_sel_n = 1'b1;
        tick(HALF_CLKS);
        mode = 1'b1;
        tick(HALF_CLKS);
        check("R8 req frozen", req, 1);
        check("R8 addr frozen", dev_addr, 5'h09);
    endtask

    task automatic t_idle;
        m_sel_n = 1'b0; m_sclk = 1'b1; m_mosi = 1'b1;
        #1;
        check("R9 bus_sel_n", bus_sel_n, 1);
        check("R9 bus_sclk", bus_sclk, 0);
        check("R9 bus_mosi", bus_mosi, 0);
        m_sclk = 1'b0; m_mosi = 1'b0; m_sel_n = 1'b1;
        tick(4 * HALF_CLKS);
    endtask

    task automatic t_desel;
        grant = 1'b1;
        tick(HALF_CLKS);
        check("R10 miso deselected", m_miso, 1);
        grant = 1'b0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_write();
        t_dont_care();
        t_partial();
        t_handshake();
        t_boundary();
        t_release();
        t_pass();
        t_idle();
        t_desel();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

endmodule